// File: doc/BRIEF.md
# MSI Doorbell Interrupt Controller

This block sits inside a PCIe root complex, behind the logic that has already unpacked inbound memory writes. It turns message-signalled interrupt writes into a single level-sensitive interrupt line toward the processor. Software programs a 64-bit doorbell address, which is loaded as two 32-bit halves, and a 32-bit enable word. While the enable word is nonzero, a 4-byte doorbell window at that address is live. A full-word write of value v into the window latches pending bit v in a 32-bit status word, provided that vector v is enabled.

The interrupt line rises after a doorbell write that leaves any pending bit unmasked. It falls only after a software write to the status word leaves that word entirely empty. Software toggles status bits by writing a value that is XORed into the status word. Writing the mask word only stores the new mask and never moves the line by itself.

Top module: `msidb_ctrl`

## Requirements
- R1: After reset, the base halves, enable, mask and status all read zero and `irq` is low.
- R2: Register select codes are 0 = base bits 31:0, 1 = base bits 63:32, 2 = enable, 3 = mask, 4 = status. Other codes read zero. Writing select 0 replaces only base bits 31:0. Writing select 1 replaces only bits 63:32. Each half reads back its current value.
- R3: The enable, mask and status registers each read back their current value on `reg_rdata`, combinationally from `reg_sel`.
- R4: A doorbell write (`db_valid`=1, `db_write`=1, `db_be`=4'hF) of value v (0 to 31) that hits the window sets status bit v if enable bit v is 1, and keeps all other status bits. If enable bit v is 0, status is unchanged.
- R5: The window hits only when all 64 bits of `db_addr` equal the base and the enable register is nonzero. Doorbell writes to any other address, or made while enable is zero, change nothing.
- R6: `db_rdata` is always zero, including for reads that hit the window. Doorbell reads change no state.
- R7: Doorbell writes with a value of 32 or more, or with `db_be` other than 4'hF, are ignored.
- R8: One cycle after an accepted doorbell write, `irq` is high if any status bit is set whose mask bit is 0. Otherwise `irq` keeps its level.
- R9: A write to select 4 XORs `reg_wdata` into the status word, taking effect on the next clock edge.
- R10: After a status write, `irq` goes low only if the whole status word is zero, with or without mask bits. Otherwise `irq` keeps its level.
- R11: A write to the mask register leaves `irq` unchanged.
- R12: When a status write and an accepted doorbell write occur in the same cycle, the XOR is applied first and the doorbell bit is ORed into the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select code |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |
| db_valid | input | 1 | Doorbell access valid |
| db_write | input | 1 | Doorbell access is a write (1) or a read (0) |
| db_addr | input | 64 | Doorbell access byte address |
| db_be | input | 4 | Doorbell byte enables |
| db_wdata | input | 32 | Doorbell write data (vector number) |
| db_rdata | output | 32 | Doorbell read data, always zero |
| irq | output | 1 | Level interrupt toward the processor |

## Verification
The checker relies on a few assumptions about the inputs:
- `reg_sel` and `reg_wdata` are stable whenever `reg_we` is high.
- `db_addr` is word aligned when a full 32-bit access is made.
- Doorbell and register inputs change only between clock edges.

The bench drives every input on the falling edge and holds it for one full cycle. It uses aligned doorbell addresses, except where it deliberately probes the address four bytes past the base and an address with different upper bits. It combines a status write with a doorbell write only in the scenario written for that case.

// File: rtl/msidb_pkg.sv
package msidb_pkg;
   localparam int SEL_W = 3;

   typedef enum logic [SEL_W-1:0] {
      SEL_BASE_LO = 3'd0,
      SEL_BASE_HI = 3'd1,
      SEL_ENABLE  = 3'd2,
      SEL_MASK    = 3'd3,
      SEL_STATUS  = 3'd4
   } msidb_sel_e;
endpackage

// File: rtl/msidb_window.sv
// Address decode for the 4-byte doorbell window.
module msidb_window #(
   parameter int ADDR_W = 64
) (
   input  logic [ADDR_W-1:0] base,
   input  logic              live,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   always_comb hit = live && (addr == base);
endmodule

// File: rtl/msidb_vec_decode.sv
// Turns a doorbell data word into a one-hot vector select, qualified by byte enables.
module msidb_vec_decode #(
   parameter int DATA_W = 32,
   parameter int NVEC   = 32
) (
   input  logic [DATA_W-1:0]   wdata,
   input  logic [DATA_W/8-1:0] be,
   output logic                ok,
   output logic [NVEC-1:0]     onehot
);
   localparam int BE_W = DATA_W / 8;

   always_comb ok = (be == {BE_W{1'b1}}) && (wdata < DATA_W'(NVEC));

   for (genvar i = 0; i < NVEC; i++) begin : g_vec
      assign onehot[i] = (wdata == DATA_W'(i));
   end
endmodule

// File: rtl/msidb_status_bank.sv
// Pending-status word and interrupt level register.
module msidb_status_bank #(
   parameter int NVEC = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sw_wr,
   input  logic [NVEC-1:0] sw_val,
   input  logic            db_evt,
   input  logic [NVEC-1:0] set_vec,
   input  logic [NVEC-1:0] mask,
   output logic [NVEC-1:0] status_q,
   output logic            irq_q
);
   logic [NVEC-1:0] status_n;

   for (genvar i = 0; i < NVEC; i++) begin : g_bit
      // toggle first, then the doorbell bit is ORed on top
      assign status_n[i] = (status_q[i] ^ (sw_wr & sw_val[i])) | set_vec[i];

      always_ff @(posedge clk) begin
         if (!rst_n) status_q[i] <= 1'b0;
         else        status_q[i] <= status_n[i];
      end
   end

   logic irq_n;
   always_comb begin
      irq_n = irq_q;
      if (db_evt && ((status_n & ~mask) != '0)) irq_n = 1'b1;
      else if (sw_wr && (status_n == '0))      irq_n = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= irq_n;
   end
endmodule

// File: rtl/msidb_ctrl.sv
module msidb_ctrl
   import msidb_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 64,
   parameter int NVEC   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              db_valid,
   input  logic              db_write,
   input  logic [ADDR_W-1:0] db_addr,
   input  logic [DATA_W/8-1:0] db_be,
   input  logic [DATA_W-1:0] db_wdata,
   output logic [DATA_W-1:0] db_rdata,
   output logic              irq
);
   localparam int HALF = ADDR_W / 2;

   if (ADDR_W != 2 * DATA_W) begin : g_bad_addr
      $error("msidb_ctrl: ADDR_W must be twice DATA_W");
   end
   if (NVEC != DATA_W) begin : g_bad_nvec
      $error("msidb_ctrl: NVEC must equal DATA_W");
   end
   if (DATA_W % 8 != 0) begin : g_bad_data
      $error("msidb_ctrl: DATA_W must be a whole number of bytes");
   end

   logic [ADDR_W-1:0] base_q;
   logic [NVEC-1:0]   enable_q;
   logic [NVEC-1:0]   mask_q;
   logic [NVEC-1:0]   status_q;

   // software register writes
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q   <= '0;
         enable_q <= '0;
         mask_q   <= '0;
      end else if (reg_we) begin
         case (reg_sel)
            SEL_BASE_LO: base_q[HALF-1:0]      <= reg_wdata;
            SEL_BASE_HI: base_q[ADDR_W-1:HALF] <= reg_wdata;
            SEL_ENABLE:  enable_q              <= reg_wdata;
            SEL_MASK:    mask_q                <= reg_wdata;
            default: ;
         endcase
      end
   end

   logic sw_status_wr;
   always_comb sw_status_wr = reg_we && (reg_sel == SEL_STATUS);

   // doorbell path
   logic            win_hit;
   logic            vec_ok;
   logic [NVEC-1:0] vec_onehot;
   logic            db_evt;
   logic [NVEC-1:0] set_vec;

   msidb_window #(.ADDR_W(ADDR_W)) u_win (
      .base (base_q),
      .live (|enable_q),
      .addr (db_addr),
      .hit  (win_hit)
   );

   msidb_vec_decode #(.DATA_W(DATA_W), .NVEC(NVEC)) u_dec (
      .wdata  (db_wdata),
      .be     (db_be),
      .ok     (vec_ok),
      .onehot (vec_onehot)
   );

   always_comb begin
      db_evt  = db_valid && db_write && win_hit && vec_ok;
      set_vec = db_evt ? (vec_onehot & enable_q) : '0;
   end

   msidb_status_bank #(.NVEC(NVEC)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .sw_wr    (sw_status_wr),
      .sw_val   (reg_wdata),
      .db_evt   (db_evt),
      .set_vec  (set_vec),
      .mask     (mask_q),
      .status_q (status_q),
      .irq_q    (irq)
   );

   // read side
   always_comb begin
      case (reg_sel)
         SEL_BASE_LO: reg_rdata = base_q[HALF-1:0];
         SEL_BASE_HI: reg_rdata = base_q[ADDR_W-1:HALF];
         SEL_ENABLE:  reg_rdata = enable_q;
         SEL_MASK:    reg_rdata = mask_q;
         SEL_STATUS:  reg_rdata = status_q;
         default:     reg_rdata = '0;
      endcase
   end

   assign db_rdata = '0;
endmodule

// File: rtl/msidb_checker.sv
module msidb_checker #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 64,
   parameter int NVEC   = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic [2:0]        reg_sel,
   input logic [DATA_W-1:0] reg_wdata,
   input logic              db_valid,
   input logic              db_write,
   input logic [ADDR_W-1:0] db_addr,
   input logic [DATA_W/8-1:0] db_be,
   input logic [DATA_W-1:0] db_wdata,
   input logic              irq,
   input logic [ADDR_W-1:0] base_q,
   input logic [NVEC-1:0]   enable_q,
   input logic [NVEC-1:0]   mask_q,
   input logic [NVEC-1:0]   status_q
);
   localparam int IDX_W = $clog2(NVEC);
   localparam int BE_W  = DATA_W / 8;

   logic sw_st;
   logic full_wr;
   assign sw_st   = reg_we && (reg_sel == 3'd4);
   assign full_wr = db_valid && db_write && (db_be == {BE_W{1'b1}});

   a_r4_set_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_st && full_wr && db_addr == base_q && enable_q != '0 &&
       db_wdata < DATA_W'(NVEC) && enable_q[db_wdata[IDX_W-1:0]])
      |=> status_q[$past(db_wdata[IDX_W-1:0])]);

   a_r5_dead_window: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_st && (enable_q == '0 || db_addr != base_q)) |=> $stable(status_q));

   a_r7_partial_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_st && db_valid && (db_be != {BE_W{1'b1}} || db_wdata >= DATA_W'(NVEC)))
      |=> $stable(status_q));

   a_r8_rise_needs_doorbell: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(db_valid && db_write) && ((status_q & ~mask_q) != '0)));

   a_r9_xor_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_st && !db_valid) |=> status_q == ($past(status_q) ^ $past(reg_wdata)));

   a_r10_fall_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> (status_q == '0 && $past(sw_st)));

   a_r11_mask_keeps_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_sel == 3'd3 && !db_valid) |=> $stable(irq));
endmodule

bind msidb_ctrl msidb_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NVEC(NVEC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_sel   (reg_sel),
   .reg_wdata (reg_wdata),
   .db_valid  (db_valid),
   .db_write  (db_write),
   .db_addr   (db_addr),
   .db_be     (db_be),
   .db_wdata  (db_wdata),
   .irq       (irq),
   .base_q    (base_q),
   .enable_q  (enable_q),
   .mask_q    (mask_q),
   .status_q  (status_q)
);

// File: tb/sim_msidb_ctrl.sv
`timescale 1ns/1ps
module sim_msidb_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_sel = 3'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        db_valid = 1'b0;
   logic        db_write = 1'b0;
   logic [63:0] db_addr = '0;
   logic [3:0]  db_be = 4'h0;
   logic [31:0] db_wdata = '0;
   logic [31:0] db_rdata;
   logic        irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   localparam logic [63:0] BASE = 64'h0000_0001_FEE0_0000;

   always #2.5 clk = ~clk;

   msidb_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .db_valid(db_valid),
      .db_write(db_write), .db_addr(db_addr), .db_be(db_be),
      .db_wdata(db_wdata), .db_rdata(db_rdata), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [2:0] sel, input logic [31:0] val);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_check(input string req, input logic [2:0] sel, input logic [31:0] exp);
      reg_sel = sel;
      #0.5;
      check(req, reg_rdata, exp);
   endtask

   task automatic db_access(input logic wr, input logic [63:0] a, input logic [3:0] be,
                            input logic [31:0] v);
      @(negedge clk);
      db_valid = 1'b1; db_write = wr; db_addr = a; db_be = be; db_wdata = v;
      #0.5;
      if (!wr) check("R6 read data", db_rdata, 32'h0);
      @(negedge clk);
      db_valid = 1'b0; db_write = 1'b0;
   endtask

   task automatic t_reset();
      reg_check("R1 base lo", 3'd0, 32'h0);
      reg_check("R1 base hi", 3'd1, 32'h0);
      reg_check("R1 enable", 3'd2, 32'h0);
      reg_check("R1 mask", 3'd3, 32'h0);
      reg_check("R1 status", 3'd4, 32'h0);
      check("R1 irq", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_base();
      reg_write(3'd0, 32'h1111_2222);
      reg_write(3'd1, 32'h0000_0001);
      reg_check("R2 lo kept by hi write", 3'd0, 32'h1111_2222);
      reg_write(3'd0, BASE[31:0]);
      reg_check("R2 hi kept by lo write", 3'd1, 32'h0000_0001);
      reg_check("R2 lo", 3'd0, BASE[31:0]);
      reg_check("R2 unused select", 3'd6, 32'h0);
   endtask

   task automatic t_disabled();
      db_access(1'b1, BASE, 4'hF, 32'd3);
      reg_check("R5 enable zero blocks window", 3'd4, 32'h0);
   endtask

   task automatic t_set();
      reg_write(3'd2, 32'h0000_00FF);
      reg_check("R3 enable readback", 3'd2, 32'h0000_00FF);
      db_access(1'b1, BASE, 4'hF, 32'd3);
      reg_check("R4 bit 3 set", 3'd4, 32'h8);
      check("R8 irq after doorbell", {31'b0, irq}, 32'h1);
      db_access(1'b1, BASE, 4'hF, 32'd10);
      reg_check("R4 disabled vector", 3'd4, 32'h8);
      db_access(1'b1, BASE, 4'hF, 32'd0);
      reg_check("R4 other bits kept", 3'd4, 32'h9);
   endtask

   task automatic t_ignored();
      db_access(1'b1, BASE, 4'hF, 32'd40);
      reg_check("R7 value out of range", 3'd4, 32'h9);
      db_access(1'b1, BASE, 4'h3, 32'd5);
      reg_check("R7 partial byte enables", 3'd4, 32'h9);
      db_access(1'b1, BASE + 64'd4, 4'hF, 32'd5);
      reg_check("R5 address past window", 3'd4, 32'h9);
      db_access(1'b1, {32'h2, BASE[31:0]}, 4'hF, 32'd5);
      reg_check("R5 upper bits differ", 3'd4, 32'h9);
      db_access(1'b0, BASE, 4'hF, 32'd5);
      reg_check("R6 read leaves status", 3'd4, 32'h9);
   endtask

   task automatic t_xor();
      reg_write(3'd4, 32'h1);
      reg_check("R9 xor clears bit 0", 3'd4, 32'h8);
      check("R10 irq held while nonzero", {31'b0, irq}, 32'h1);
      reg_write(3'd3, 32'h8);
      reg_check("R3 mask readback", 3'd3, 32'h8);
      check("R11 mask write keeps irq", {31'b0, irq}, 32'h1);
      reg_write(3'd4, 32'h8);
      reg_check("R9 status empty", 3'd4, 32'h0);
      check("R10 irq falls on empty", {31'b0, irq}, 32'h0);
      db_access(1'b1, BASE, 4'hF, 32'd3);
      check("R8 masked bit keeps irq low", {31'b0, irq}, 32'h0);
      reg_write(3'd3, 32'h0);
      check("R11 unmask keeps irq low", {31'b0, irq}, 32'h0);
      reg_write(3'd4, 32'h8);
      reg_write(3'd4, 32'h2);
      reg_check("R9 xor sets bit", 3'd4, 32'h2);
      check("R10 xor set leaves irq low", {31'b0, irq}, 32'h0);
      reg_write(3'd4, 32'h2);
      reg_check("R9 toggle back", 3'd4, 32'h0);
   endtask

   task automatic t_same_cycle();
      @(negedge clk);
      reg_we = 1'b1; reg_sel = 3'd4; reg_wdata = 32'h10;
      db_valid = 1'b1; db_write = 1'b1; db_addr = BASE; db_be = 4'hF; db_wdata = 32'd4;
      @(negedge clk);
      reg_we = 1'b0; db_valid = 1'b0; db_write = 1'b0;
      reg_check("R12 xor then or same bit", 3'd4, 32'h10);
      check("R12 irq raised", {31'b0, irq}, 32'h1);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = 3'd4; reg_wdata = 32'h10;
      db_valid = 1'b1; db_write = 1'b1; db_wdata = 32'd5;
      @(negedge clk);
      reg_we = 1'b0; db_valid = 1'b0; db_write = 1'b0;
      reg_check("R12 cleared bit and new bit", 3'd4, 32'h20);
      check("R12 irq stays high", {31'b0, irq}, 32'h1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_base();
      t_disabled();
      t_set();
      t_ignored();
      t_xor();
      t_same_cycle();
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule